// File: doc/BRIEF.md
# Cascadable Multi-Carrier Complex Summer

This block combines the complex baseband samples of four modulated channels into one multi-carrier complex stream. The real parts and the imaginary parts are added in two separate paths. The result, called the local sum, is clamped to a 20-bit signed range. Clamping instead of wrapping keeps overload from turning a large positive peak into a large negative one.

Several of these blocks can form a daisy chain to carry more carriers. Up to four blocks give up to sixteen carriers. Each block adds the upstream block's complex stream, which arrives on the cascade input, to its own local sum and drives the total on the cascade output. Because the upstream data reaches each block later the further down the chain it sits, a 2-bit chain-position input delays the local sum by one cycle per position. This lines the local sum up with the cascade data. When a block has no upstream neighbour, a cascade-enable input forces the cascade input to zero. An input-valid flag travels through the same delay as the data and comes out as an output-valid flag.

Top module: `cascade_summer`

## Requirements
- R1: `sum_re` is the sum of the four real channel samples and `sum_im` is the sum of the four imaginary channel samples. Channel k occupies bits [20k+19:20k] of `ch_re` and of `ch_im`, as a 20-bit two's complement value.
- R2: `cas_out_re` and `cas_out_im` equal the local sum plus the cascade input, part by part. The cascade input is sampled one clock edge before it shows on the cascade outputs.
- R3: While `cas_en` is 0, the cascade input has no effect and the cascade outputs equal the local sum in the same cycle.
- R4: With `cas_pos` = p (0 to 3), a channel sample appears on `sum_*` and contributes to `cas_out_*` exactly 2+p clock edges after it is applied.
- R5: The local sum saturates: a true sum above 524287 gives 524287, and a true sum below -524288 gives -524288.
- R6: The cascade sum is formed from the saturated local sum and saturates to the same limits, +524287 and -524288.
- R7: `out_valid` is `in_valid` delayed by the same 2+p edges, so it is 1 exactly in the cycles that carry a valid sample.
- R8: While `rst` is high at a clock edge, all data outputs and `out_valid` become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks the channel samples as valid |
| ch_re | input | 80 | Four real channel samples, channel k at bits [20k+19:20k] |
| ch_im | input | 80 | Four imaginary channel samples, same packing |
| cas_en | input | 1 | 1 uses the cascade input, 0 forces it to zero |
| cas_pos | input | 2 | Position of this block in the chain |
| cas_in_re | input | 20 | Cascade input, real part |
| cas_in_im | input | 20 | Cascade input, imaginary part |
| sum_re | output | 20 | Delayed local sum, real part |
| sum_im | output | 20 | Delayed local sum, imaginary part |
| cas_out_re | output | 20 | Cascade output, real part |
| cas_out_im | output | 20 | Cascade output, imaginary part |
| out_valid | output | 1 | Valid flag aligned with `sum_*` |

## Verification
The bench first drives sums that overflow in both directions, in the local adder and then again at the cascade adder. A design that wrapped instead of clamping would show a sign flip there. Next it sends a single-cycle pulse at each chain position and checks the exact cycle it emerges. A wrong tap would make the pulse arrive early or late, or leave `out_valid` misaligned with the data. It then drives large cascade values with the enable cleared, which would leak into the outputs if the gating were missing. It also drives a one-cycle cascade value, which would catch an extra or missing register on the cascade path. Last, it pulses reset in the middle of a run to catch any output that keeps stale state.

// File: rtl/csum_pkg.sv
package csum_pkg;
  localparam int SAMPLE_W = 20;
  localparam int CAS_ACC_W = SAMPLE_W + 1;

  typedef struct packed {
    logic signed [SAMPLE_W-1:0] re;
    logic signed [SAMPLE_W-1:0] im;
  } cplx_t;

  localparam int CPLX_W = 2 * SAMPLE_W;

  // Clamp a two-operand sum back into the sample range.
  function automatic logic signed [SAMPLE_W-1:0] clamp_cas(
      input logic signed [CAS_ACC_W-1:0] v);
    logic signed [CAS_ACC_W-1:0] hi;
    logic signed [CAS_ACC_W-1:0] lo;
    hi = CAS_ACC_W'((64'sd1 <<< (SAMPLE_W-1)) - 64'sd1);
    lo = -hi - CAS_ACC_W'(1);
    if (v > hi)      clamp_cas = hi[SAMPLE_W-1:0];
    else if (v < lo) clamp_cas = lo[SAMPLE_W-1:0];
    else             clamp_cas = v[SAMPLE_W-1:0];
  endfunction
endpackage

// File: rtl/csum_adder.sv
module csum_adder
  import csum_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic [NUM_CH*SAMPLE_W-1:0] ch_re,
  input  logic [NUM_CH*SAMPLE_W-1:0] ch_im,
  output cplx_t                      sum_q,
  output logic                       vld_q
);
  localparam int ACC_W = SAMPLE_W + $clog2(NUM_CH) + 1;
  localparam logic signed [ACC_W-1:0] HI = ACC_W'((64'sd1 <<< (SAMPLE_W-1)) - 64'sd1);
  localparam logic signed [ACC_W-1:0] LO = -HI - ACC_W'(1);

  logic signed [ACC_W-1:0] acc_re, acc_im;
  logic signed [SAMPLE_W-1:0] sat_re, sat_im;

  always_comb begin
    acc_re = '0;
    acc_im = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      acc_re = acc_re + ACC_W'($signed(ch_re[k*SAMPLE_W +: SAMPLE_W]));
      acc_im = acc_im + ACC_W'($signed(ch_im[k*SAMPLE_W +: SAMPLE_W]));
    end
  end

  always_comb begin
    if (acc_re > HI)      sat_re = HI[SAMPLE_W-1:0];
    else if (acc_re < LO) sat_re = LO[SAMPLE_W-1:0];
    else                  sat_re = acc_re[SAMPLE_W-1:0];
    if (acc_im > HI)      sat_im = HI[SAMPLE_W-1:0];
    else if (acc_im < LO) sat_im = LO[SAMPLE_W-1:0];
    else                  sat_im = acc_im[SAMPLE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q <= '0;
      vld_q <= 1'b0;
    end else begin
      sum_q.re <= sat_re;
      sum_q.im <= sat_im;
      vld_q    <= in_valid;
    end
  end

  // Sign flags of the raw inputs, used only by the overflow checks.
  logic re_all_pos, re_all_neg;
  always_comb begin
    re_all_pos = 1'b1;
    re_all_neg = 1'b1;
    for (int k = 0; k < NUM_CH; k++) begin
      if (ch_re[k*SAMPLE_W + SAMPLE_W - 1])  re_all_pos = 1'b0;
      if (!ch_re[k*SAMPLE_W + SAMPLE_W - 1]) re_all_neg = 1'b0;
    end
  end

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    $past(re_all_pos) |-> !sum_q.re[SAMPLE_W-1]);
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
    $past(re_all_neg) |-> sum_q.re[SAMPLE_W-1]);
endmodule

// File: rtl/csum_delay.sv
module csum_delay #(
  parameter int WIDTH = 41,
  parameter int POS_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [POS_W-1:0] pos,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  localparam int MAX_POS = (1 << POS_W) - 1;

  logic [WIDTH-1:0] taps [0:MAX_POS];

  assign taps[0] = din;

  for (genvar s = 1; s <= MAX_POS; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) taps[s] <= '0;
      else     taps[s] <= taps[s-1];
    end
  end

  assign dout = taps[pos];

  assert_one_stage_R4: assert property (@(posedge clk) disable iff (rst)
    (pos == POS_W'(1)) |-> (dout == $past(din)));
  assert_no_stage_R4: assert property (@(posedge clk) disable iff (rst)
    (pos == '0) |-> (dout == din));
endmodule

// File: rtl/csum_cascade.sv
module csum_cascade
  import csum_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  cplx_t local_in,
  input  logic  local_vld,
  input  cplx_t cas_in,
  input  logic  cas_en,
  output cplx_t sum_q,
  output cplx_t cas_q,
  output logic  vld_q
);
  cplx_t cas_gated;
  logic signed [CAS_ACC_W-1:0] add_re, add_im;

  always_comb begin
    cas_gated = cas_en ? cas_in : '0;
    add_re = CAS_ACC_W'(local_in.re) + CAS_ACC_W'(cas_gated.re);
    add_im = CAS_ACC_W'(local_in.im) + CAS_ACC_W'(cas_gated.im);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q <= '0;
      cas_q <= '0;
      vld_q <= 1'b0;
    end else begin
      sum_q    <= local_in;
      cas_q.re <= clamp_cas(add_re);
      cas_q.im <= clamp_cas(add_im);
      vld_q    <= local_vld;
    end
  end

  assert_gate_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(cas_en) |-> (cas_q == $past(local_in)));
  assert_cas_no_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(cas_en) && !$past(local_in.re[SAMPLE_W-1]) && !$past(cas_in.re[SAMPLE_W-1]))
      |-> !cas_q.re[SAMPLE_W-1]);
  assert_local_pass_R2: assert property (@(posedge clk) disable iff (rst)
    sum_q == $past(local_in));
endmodule

// File: rtl/cascade_summer.sv
module cascade_summer
  import csum_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int POS_W  = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic [NUM_CH*SAMPLE_W-1:0] ch_re,
  input  logic [NUM_CH*SAMPLE_W-1:0] ch_im,
  input  logic                       cas_en,
  input  logic [POS_W-1:0]           cas_pos,
  input  logic [SAMPLE_W-1:0]        cas_in_re,
  input  logic [SAMPLE_W-1:0]        cas_in_im,
  output logic [SAMPLE_W-1:0]        sum_re,
  output logic [SAMPLE_W-1:0]        sum_im,
  output logic [SAMPLE_W-1:0]        cas_out_re,
  output logic [SAMPLE_W-1:0]        cas_out_im,
  output logic                       out_valid
);
  localparam int DLY_W = CPLX_W + 1;

  cplx_t local_sum, local_dly, cas_in, sum_q, cas_q;
  logic  local_vld, dly_vld, vld_q;
  logic [DLY_W-1:0] dly_out;

  csum_adder #(.NUM_CH(NUM_CH)) u_adder (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .ch_re(ch_re), .ch_im(ch_im),
    .sum_q(local_sum), .vld_q(local_vld)
  );

  csum_delay #(.WIDTH(DLY_W), .POS_W(POS_W)) u_delay (
    .clk(clk), .rst(rst), .pos(cas_pos),
    .din({local_vld, local_sum}), .dout(dly_out)
  );

  assign local_dly = dly_out[CPLX_W-1:0];
  assign dly_vld   = dly_out[CPLX_W];
  assign cas_in.re = cas_in_re;
  assign cas_in.im = cas_in_im;

  csum_cascade u_cascade (
    .clk(clk), .rst(rst),
    .local_in(local_dly), .local_vld(dly_vld),
    .cas_in(cas_in), .cas_en(cas_en),
    .sum_q(sum_q), .cas_q(cas_q), .vld_q(vld_q)
  );

  assign sum_re     = sum_q.re;
  assign sum_im     = sum_q.im;
  assign cas_out_re = cas_q.re;
  assign cas_out_im = cas_q.im;
  assign out_valid  = vld_q;

  assert_valid_pos0_R7: assert property (@(posedge clk) disable iff (rst)
    (cas_pos == '0 && $past(cas_pos) == '0) |-> (out_valid == $past(in_valid, 2)));
endmodule

// File: tb/cascade_summer_bench.sv
`timescale 1ns/1ps
module cascade_summer_bench;
  localparam int SW = 20;
  localparam int NV = 6;
  // columns: re0..re3, im0..im3, cas_re, cas_im, en, exp sum re/im, exp cas re/im
  localparam int VEC [NV][15] = '{
    '{1, 2, 3, 4, -1, -2, -3, -4, 10, -10, 1, 10, -10, 20, -20},
    '{1, 2, 3, 4, -1, -2, -3, -4, 100, 100, 0, 10, -10, 10, -10},
    '{300000, 300000, 300000, 300000, -300000, -300000, -300000, -300000,
      5, 5, 1, 524287, -524288, 524287, -524283},
    '{200000, 100000, -50000, 0, 100000, 100000, 100000, 100000,
      300000, -500000, 1, 250000, 400000, 524287, -100000},
    '{-524288, -524288, -524288, -524288, 524287, -524288, 0, 0,
      -1, 0, 1, -524288, -1, -524288, -1},
    '{0, 0, 0, 0, 0, 0, 0, 0, -524288, 524287, 1, 0, 0, -524288, 524287}
  };

  logic clk = 1'b0;
  logic rst;
  logic in_valid, cas_en;
  logic [4*SW-1:0] ch_re, ch_im;
  logic [1:0] cas_pos;
  logic [SW-1:0] cas_in_re, cas_in_im;
  logic [SW-1:0] sum_re, sum_im, cas_out_re, cas_out_im;
  logic out_valid;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cascade_summer u_cascade_summer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .ch_re(ch_re), .ch_im(ch_im),
    .cas_en(cas_en), .cas_pos(cas_pos), .cas_in_re(cas_in_re), .cas_in_im(cas_in_im),
    .sum_re(sum_re), .sum_im(sum_im), .cas_out_re(cas_out_re),
    .cas_out_im(cas_out_im), .out_valid(out_valid)
  );

  function automatic int sx(input logic [SW-1:0] v);
    return int'($signed(v));
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    in_valid = 0; cas_en = 0; ch_re = '0; ch_im = '0;
    cas_in_re = '0; cas_in_im = '0;
  endtask

  task automatic check_zero(input string req);
    chk(req, sx(sum_re), 0);
    chk(req, sx(sum_im), 0);
    chk(req, sx(cas_out_re), 0);
    chk(req, sx(cas_out_im), 0);
    chk(req, int'(out_valid), 0);
  endtask

  // Single-cycle pulse through chain position p: visible after exactly 2+p edges.
  task automatic latency(input int p);
    int t;
    @(negedge clk);
    idle(); cas_pos = 2'(p);
    repeat (6) @(negedge clk);
    t = 1000 + p;
    in_valid = 1;
    ch_re[2*SW +: SW] = t[SW-1:0];
    t = -7;
    ch_im[0 +: SW] = t[SW-1:0];
    for (int c = 1; c <= 3 + p; c++) begin
      @(negedge clk);
      if (c == 1) idle();
      if (c == 1 + p) chk("R7 early", int'(out_valid), 0);
      if (c == 2 + p) begin
        chk("R7 aligned", int'(out_valid), 1);
        chk("R4 sum_re at 2+p", sx(sum_re), 1000 + p);
        chk("R1 sum_im at 2+p", sx(sum_im), -7);
        chk("R4 cas_re at 2+p", sx(cas_out_re), 1000 + p);
      end
      if (c == 3 + p) begin
        chk("R7 one cycle", int'(out_valid), 0);
        chk("R4 pulse ends", sx(sum_re), 0);
      end
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R8 actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int t;
    rst = 1; idle(); cas_pos = 0;
    repeat (4) @(negedge clk);
    check_zero("R8 reset");
    rst = 0;

    // Steady-state vector table at position 0.
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      in_valid = 1;
      for (int k = 0; k < 4; k++) begin
        t = VEC[v][k];     ch_re[k*SW +: SW] = t[SW-1:0];
        t = VEC[v][4 + k]; ch_im[k*SW +: SW] = t[SW-1:0];
      end
      t = VEC[v][8]; cas_in_re = t[SW-1:0];
      t = VEC[v][9]; cas_in_im = t[SW-1:0];
      cas_en = VEC[v][10] != 0;
      repeat (5) @(negedge clk);
      chk("R1 R5 sum_re", sx(sum_re), VEC[v][11]);
      chk("R1 R5 sum_im", sx(sum_im), VEC[v][12]);
      chk("R2 R3 R6 cas_re", sx(cas_out_re), VEC[v][13]);
      chk("R2 R3 R6 cas_im", sx(cas_out_im), VEC[v][14]);
      chk("R7 valid held", int'(out_valid), 1);
    end

    for (int p = 0; p < 4; p++) latency(p);

    // R2: cascade input reaches the output after one edge.
    @(negedge clk);
    idle(); cas_pos = 0; cas_en = 1;
    repeat (6) @(negedge clk);
    cas_in_re = 20'(123);
    t = -77; cas_in_im = t[SW-1:0];
    chk("R2 before edge", sx(cas_out_re), 0);
    @(negedge clk);
    chk("R2 cas_re one edge", sx(cas_out_re), 123);
    chk("R2 cas_im one edge", sx(cas_out_im), -77);
    cas_in_re = '0; cas_in_im = '0;
    @(negedge clk);
    chk("R2 cas clears", sx(cas_out_re), 0);

    // R3: disabled cascade with large input leaves cascade out equal to sum.
    cas_en = 0;
    cas_in_re = 20'(400000); cas_in_im = 20'(400000);
    repeat (2) @(negedge clk);
    chk("R3 ignored re", sx(cas_out_re), 0);
    chk("R3 ignored im", sx(cas_out_im), 0);

    // R8: reset in mid-run.
    in_valid = 1; ch_re[0 +: SW] = 20'(55); cas_en = 1;
    repeat (5) @(negedge clk);
    chk("R1 pre-reset", sx(sum_re), 55);
    rst = 1;
    repeat (2) @(negedge clk);
    check_zero("R8 mid-run reset");
    rst = 0; idle();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule